// File: doc/BRIEF.md
# Page-Bounded Flash Write Splitter

This block sits in front of a serial NOR flash command engine. It turns one write request into a series of page program commands. A request gives a start address and a byte count. The splitter emits one command for each piece of the request that lies inside a single flash page. The first piece is cut short at the end of its page when the start address is not page-aligned. Every later piece starts on a page boundary. Each command carries an opcode, a flash address and a byte count, and it is handed out over a valid/ready handshake. A one-cycle done pulse follows the final command.

Two configuration inputs are sampled when a request is accepted. One selects the page size: 256 or 512 bytes. The other selects the addressing mode: 3-byte or 4-byte. The addressing mode also fixes the opcode of every command for that request. The target region is assumed to be erased already. Moving the data bytes onto the serial bus, erasing, polling status and setting write-enable are all done elsewhere.

Top module: `flash_wr_splitter`

## Requirements
- R1: Each command length equals the smaller of two values: the bytes left in the request, and the bytes from the command address to the end of its page. The page is the aligned block whose size is set by the configuration.
- R2: No command has a length of zero, and no command has a length greater than the selected page size.
- R3: A request may start at any byte offset. A command that follows another command within the same request always starts at a page-aligned address.
- R4: With `cfg_page_512` = 0 the page size is 256 bytes. With `cfg_page_512` = 1 the page size is 512 bytes. The value is taken when the request is accepted.
- R5: With `cfg_addr4` = 1 the opcode is 8'h12. With `cfg_addr4` = 0 the opcode is 8'h02. In the 0 case, `cmd_addr[31:24]` is zero and addresses wrap from 24'hFFFFFF to 0. The mode is taken when the request is accepted.
- R6: While `cmd_valid` is high and `cmd_ready` is low, the command outputs hold their values.
- R7: A request with a length of zero produces no command. Its `done` is high in the cycle after it is accepted.
- R8: Each command address equals the previous command address plus the previous length. The lengths add up to the request length. `done` is high for exactly one cycle, in the cycle after the last command's handshake.
- R9: `req_ready` is high while the block is idle. It stays low from the cycle after an accept through the cycle in which `done` is high.
- R10: While reset is held, `req_ready` is 1, `cmd_valid` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_page_512 | input | 1 | Page size select: 0 for 256 bytes, 1 for 512 bytes |
| cfg_addr4 | input | 1 | Address mode select: 0 for 3-byte, 1 for 4-byte |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | The block can take a request |
| req_addr | input | 32 | Start address of the request |
| req_len | input | 16 | Byte count of the request |
| cmd_valid | output | 1 | A page program command is offered |
| cmd_ready | input | 1 | The command consumer takes the command |
| cmd_opcode | output | 8 | Program opcode |
| cmd_addr | output | 32 | Flash address of the command |
| cmd_len | output | 10 | Byte count of the command |
| done | output | 1 | One-cycle pulse after the last command of a request |

## Verification
The bench targets four kinds of corner case:

- **Mid-page starts.** These include a start at offset 64, a start one byte before a page end, and a start 16 bytes before the end of a 512-byte page. A design that did not clip the first command would run across the page boundary.
- **Both page sizes.** The runs use whole-page and multi-page lengths at each size. A design that ignored the size select would cut at the wrong place.
- **Top of the 24-bit address space.** A run starts near 24'hFFFFFF in 3-byte mode. A design that did not wrap there would put bits above bit 23 on the bus.
- **Zero-length requests and backpressure.** Zero-length requests check that no command is emitted. Pseudo-random ready stalls check that a command does not change, and is not skipped, while it waits.

// File: rtl/fws_pkg.sv
package fws_pkg;

    localparam int ADDR_W        = 32;
    localparam int LEN_W         = 16;
    localparam int NARROW_ADDR_W = 24;
    localparam int PG_SMALL_LOG2 = 8;
    localparam int PG_LARGE_LOG2 = 9;
    localparam int CHUNK_W       = PG_LARGE_LOG2 + 1;

    localparam logic [7:0] OP_PROG_3B = 8'h02;
    localparam logic [7:0] OP_PROG_4B = 8'h12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_FIN  = 2'd2
    } fws_state_e;

    typedef struct packed {
        logic page_large;
        logic wide_addr;
    } fws_cfg_t;

    typedef struct packed {
        logic [7:0]         opcode;
        logic [ADDR_W-1:0]  addr;
        logic [CHUNK_W-1:0] len;
    } fws_cmd_t;

    function automatic logic [CHUNK_W-1:0] fws_page_bytes(input logic page_large);
        return page_large ? (CHUNK_W'(1) << PG_LARGE_LOG2)
                          : (CHUNK_W'(1) << PG_SMALL_LOG2);
    endfunction

    function automatic logic [ADDR_W-1:0] fws_mask_addr(input logic [ADDR_W-1:0] a,
                                                        input logic wide);
        logic [ADDR_W-1:0] m;
        m = wide ? '1 : ADDR_W'((64'd1 << NARROW_ADDR_W) - 64'd1);
        return a & m;
    endfunction

endpackage

// File: rtl/fws_chunk_calc.sv
module fws_chunk_calc
    import fws_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               check_en,
    input  logic [CHUNK_W-1:0] addr_low,
    input  logic [LEN_W-1:0]   remaining,
    input  logic               page_large,
    output logic [CHUNK_W-1:0] chunk_len,
    output logic               last_chunk
);

    logic [CHUNK_W-1:0] page;
    logic [CHUNK_W-1:0] offset;
    logic [CHUNK_W-1:0] room;

    always_comb begin
        page       = fws_page_bytes(page_large);
        offset     = addr_low & (page - CHUNK_W'(1));
        room       = page - offset;
        last_chunk = remaining <= LEN_W'(room);
        chunk_len  = last_chunk ? CHUNK_W'(remaining) : room;
    end

    // R1 / R3: a command ends at or before its page boundary
    p_fits_page_r1: assert property (@(posedge clk) disable iff (rst)
        check_en |-> ({1'b0, offset} + {1'b0, chunk_len}) <= {1'b0, page});

    // R2: never empty, never larger than a page
    p_len_bound_r2: assert property (@(posedge clk) disable iff (rst)
        check_en |-> (chunk_len != '0) && (chunk_len <= page));

endmodule

// File: rtl/fws_cursor.sv
module fws_cursor
    import fws_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ADDR_W-1:0]  load_addr,
    input  logic [LEN_W-1:0]   load_len,
    input  logic               load_wide,
    input  logic               step,
    input  logic [CHUNK_W-1:0] step_len,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [LEN_W-1:0]   remaining
);

    logic wide_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            remaining <= '0;
            wide_q    <= 1'b0;
        end else if (load) begin
            cur_addr  <= fws_mask_addr(load_addr, load_wide);
            remaining <= load_len;
            wide_q    <= load_wide;
        end else if (step) begin
            cur_addr  <= fws_mask_addr(cur_addr + ADDR_W'(step_len), wide_q);
            remaining <= remaining - LEN_W'(step_len);
        end
    end

    // R8: a step never consumes more than what is left
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
        step |-> LEN_W'(step_len) <= remaining);

    // R5: narrow addressing keeps the top byte clear
    p_narrow_top_r5: assert property (@(posedge clk) disable iff (rst)
        !wide_q |-> cur_addr[ADDR_W-1:NARROW_ADDR_W] == '0);

endmodule

// File: rtl/fws_ctrl.sv
module fws_ctrl
    import fws_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_len_zero,
    input  logic cmd_ready,
    input  logic last_chunk,
    output logic req_ready,
    output logic cmd_valid,
    output logic done,
    output logic load,
    output logic step
);

    fws_state_e state_q, state_d;

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        cmd_valid = (state_q == ST_EMIT);
        done      = (state_q == ST_FIN);
        load      = req_valid && req_ready;
        step      = cmd_valid && cmd_ready;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = req_len_zero ? ST_FIN : ST_EMIT;
            ST_EMIT: if (step && last_chunk) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R9: no second request while one is in flight
    p_busy_refuse_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> !req_ready);

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: empty request finishes without a command
    p_zero_len_r7: assert property (@(posedge clk) disable iff (rst)
        (load && req_len_zero) |=> (done && !cmd_valid));

    // R8: done follows the final handshake
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        (step && last_chunk) |=> (done && !cmd_valid));

endmodule

// File: rtl/flash_wr_splitter.sv
module flash_wr_splitter
    import fws_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_page_512,
    input  logic               cfg_addr4,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [7:0]         cmd_opcode,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [CHUNK_W-1:0] cmd_len,
    output logic               done
);

    fws_cfg_t           cfg_q;
    logic               load;
    logic               step;
    logic               last_chunk;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   remaining;
    logic [CHUNK_W-1:0] chunk_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q.page_large <= cfg_page_512;
            cfg_q.wide_addr  <= cfg_addr4;
        end
    end

    fws_ctrl ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_len_zero (req_len == '0),
        .cmd_ready    (cmd_ready),
        .last_chunk   (last_chunk),
        .req_ready    (req_ready),
        .cmd_valid    (cmd_valid),
        .done         (done),
        .load         (load),
        .step         (step)
    );

    fws_cursor cursor_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (req_addr),
        .load_len  (req_len),
        .load_wide (cfg_addr4),
        .step      (step),
        .step_len  (chunk_len),
        .cur_addr  (cur_addr),
        .remaining (remaining)
    );

    fws_chunk_calc chunk_i (
        .clk        (clk),
        .rst        (rst),
        .check_en   (cmd_valid),
        .addr_low   (cur_addr[CHUNK_W-1:0]),
        .remaining  (remaining),
        .page_large (cfg_q.page_large),
        .chunk_len  (chunk_len),
        .last_chunk (last_chunk)
    );

    fws_cmd_t cmd;
    always_comb begin
        cmd.opcode = cfg_q.wide_addr ? OP_PROG_4B : OP_PROG_3B;
        cmd.addr   = cur_addr;
        cmd.len    = chunk_len;
    end
    assign cmd_opcode = cmd.opcode;
    assign cmd_addr   = cmd.addr;
    assign cmd_len    = cmd.len;

    // R6: an offered command waits unchanged
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
                                       && $stable(cmd_len) && $stable(cmd_opcode)));

    // R5: a narrow-address opcode never comes with a wide address
    p_opcode_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_opcode == OP_PROG_3B) |-> cmd_addr[ADDR_W-1:NARROW_ADDR_W] == '0);

    // R3: a command that follows another in the same request starts on a page boundary
    p_aligned_next_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !last_chunk) |=> (cmd_addr[PG_SMALL_LOG2-1:0] == '0));

endmodule

// File: tb/flash_wr_splitter_tb.sv
`timescale 1ns/1ps
module flash_wr_splitter_tb_top;
    import fws_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic               cfg_page_512, cfg_addr4;
    logic               req_valid, req_ready;
    logic [ADDR_W-1:0]  req_addr;
    logic [LEN_W-1:0]   req_len;
    logic               cmd_valid, cmd_ready;
    logic [7:0]         cmd_opcode;
    logic [ADDR_W-1:0]  cmd_addr;
    logic [CHUNK_W-1:0] cmd_len;
    logic               done;

    always #2.5 clk = ~clk;

    flash_wr_splitter dut_i (
        .clk(clk), .rst(rst), .cfg_page_512(cfg_page_512), .cfg_addr4(cfg_addr4),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .done(done)
    );

    int checks = 0;
    int errors = 0;
    fws_cmd_t exp_q[$];
    logic bp_en = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor: moves cmd_ready at each falling edge, then samples and scores.
    initial begin
        logic [7:0] lfsr;
        bit         prev_stall;
        fws_cmd_t   prev;
        fws_cmd_t   e;
        lfsr       = 8'h5a;
        prev_stall = 1'b0;
        prev       = '0;
        cmd_ready  = 1'b0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cmd_ready = bp_en ? (lfsr[0] | lfsr[2]) : 1'b1;
            #1;
            if (prev_stall)
                check(cmd_valid === 1'b1 && cmd_addr == prev.addr && cmd_len == prev.len
                      && cmd_opcode == prev.opcode, "R6", "stalled command changed",
                      cmd_addr, prev.addr);
            if (cmd_valid === 1'b1 && cmd_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected command", cmd_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(cmd_opcode == e.opcode, "R5", "opcode", cmd_opcode, e.opcode);
                    check(cmd_addr == e.addr, "R8", "address", cmd_addr, e.addr);
                    check(cmd_len == e.len, "R1", "length", cmd_len, e.len);
                end
            end
            prev_stall = (cmd_valid === 1'b1) && !cmd_ready;
            prev.opcode = cmd_opcode;
            prev.addr   = cmd_addr;
            prev.len    = cmd_len;
        end
    end

    // Driver: predicts the commands, then offers the request.
    task automatic run_req(input logic [ADDR_W-1:0] a, input int len,
                           input bit p512, input bit a4);
        int       page;
        int       rem;
        int       room;
        int       c;
        int       waited;
        longint   cur;
        fws_cmd_t x;
        page = p512 ? 512 : 256;
        cur  = a4 ? longint'(a) : longint'(a & 32'h00FF_FFFF);
        rem  = len;
        while (rem > 0) begin
            room     = page - int'(cur % page);
            c        = (rem < room) ? rem : room;
            x.opcode = a4 ? 8'h12 : 8'h02;
            x.addr   = ADDR_W'(cur);
            x.len    = CHUNK_W'(c);
            exp_q.push_back(x);
            cur = cur + c;
            cur = a4 ? (cur & 64'hFFFF_FFFF) : (cur & 64'h00FF_FFFF);
            rem = rem - c;
        end
        @(negedge clk);
        req_valid    = 1'b1;
        req_addr     = a;
        req_len      = LEN_W'(len);
        cfg_page_512 = p512;
        cfg_addr4    = a4;
        #2;
        check(req_ready === 1'b1, "R9", "ready while idle", req_ready, 1);
        @(negedge clk);
        req_valid    = 1'b0;
        cfg_page_512 = ~p512;
        cfg_addr4    = ~a4;
        #2;
        if (len == 0) begin
            check(done === 1'b1, "R7", "done after empty request", done, 1);
            check(cmd_valid === 1'b0, "R7", "no command for empty request", cmd_valid, 0);
        end else begin
            check(req_ready === 1'b0, "R9", "ready low while busy", req_ready, 0);
        end
        waited = 0;
        while (done !== 1'b1 && waited < 20000) begin
            @(negedge clk);
            #2;
            if (done !== 1'b1)
                check(req_ready === 1'b0, "R9", "ready low before done", req_ready, 0);
            waited++;
        end
        check(exp_q.size() == 0, "R8", "commands left at done", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        #2;
        check(done === 1'b0, "R8", "done lasts one cycle", done, 0);
        check(req_ready === 1'b1, "R9", "ready back after done", req_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst          = 1'b1;
        req_valid    = 1'b0;
        req_addr     = '0;
        req_len      = '0;
        cfg_page_512 = 1'b0;
        cfg_addr4    = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        check(req_ready === 1'b1, "R10", "reset req_ready", req_ready, 1);
        check(cmd_valid === 1'b0, "R10", "reset cmd_valid", cmd_valid, 0);
        check(done === 1'b0, "R10", "reset done", done, 0);
        rst = 1'b0;

        run_req(32'h0000_0100, 256, 1'b0, 1'b0);   // R4 one whole small page
        run_req(32'h0000_0040, 300, 1'b0, 1'b0);   // R3 mid-page start: 192 then 108
        run_req(32'h0000_00FF, 1,   1'b0, 1'b1);   // R1 last byte of a page
        run_req(32'h0000_0010, 0,   1'b0, 1'b0);   // R7 empty request
        bp_en = 1'b1;
        run_req(32'h0000_01F0, 1000, 1'b1, 1'b1);  // R4 large page: 16, 512, 472
        run_req(32'h00FF_FFFE, 5,    1'b0, 1'b0);  // R5 24-bit wrap: 2 then 3
        run_req(32'h1234_5678, 3000, 1'b1, 1'b1);  // R2 many chunks under stalls
        run_req(32'h0000_0200, 0,    1'b1, 1'b1);  // R7 empty request, large page
        run_req(32'h0001_0080, 700,  1'b0, 1'b1);  // R1 small page, 4-byte mode
        bp_en = 1'b0;
        run_req(32'hFF00_0300, 512,  1'b1, 1'b0);  // R5 top byte dropped in 3-byte mode
        finish_run();
    end

endmodule